// File: doc/BRIEF.md
# Rotate-and-Mask Word Unit

This combinational unit performs the 32-bit rotate-left-then-mask operation of a 64-bit datapath. The low word of the source operand is rotated left by a register or immediate amount. The rotated word is copied into both halves of a 64-bit value, and a bit mask built from two 5-bit fields is applied to it. The begin field `mb_i` and the end field `me_i` name positions in big-endian order, so position 0 is the most significant bit of the low word.

Two partial masks are built. The begin mask is ones from the `mb_i` position toward the least significant bit. The end mask is ones from the most significant end of the word down to the `me_i` position. When the begin position is at or before the end position, the run is contiguous and the two partial masks are ANDed. When the begin position lies after the end position, the run wraps past the end of the word and the partial masks are ORed. Choosing the wrong combine turns a narrow field into an all-ones word.

The final mask never covers the upper 32 bits. In the AND-mask operation, bits outside the mask are cleared. In the insert operation, those bits come from the old destination value.

Top module: `rotmask_word_unit`

## Requirements
- R1: The rotate is a 32-bit left rotate of `src_i[31:0]` by `amount_i[4:0]`. `amount_i[5]` has no effect.
- R2: When `mb_i <= me_i`, the mask covers big-endian word positions `mb_i` through `me_i`, which are result bits `31-me_i` through `31-mb_i`. Exactly `me_i-mb_i+1` bits are set.
- R3: When `mb_i > me_i`, the mask covers big-endian positions at or after `mb_i` together with positions at or before `me_i`. This is `33-mb_i+me_i` bits.
- R4: When `mb_i` equals `me_i+1` modulo 32, the mask covers all 32 bits of the low word.
- R5: With `op_i`=0 (AND-mask), the result is the rotated value ANDed with the mask. Bits 63:32 and every unmasked bit are zero, and `dest_i` has no effect.
- R6: With `op_i`=1 (insert), the result is (rotated AND mask) OR (`dest_i` AND NOT mask). Bits 63:32 equal `dest_i[63:32]`.
- R7: `src_i[63:32]` has no effect on the result.
- R8: With source low word 0x91b906b9, amount 31, `mb_i`=16, `me_i`=20 and `op_i`=0, the result is 0x0000000000008000, which uses the mask 0x0000f800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Source operand; only the low word is rotated |
| dest_i | input | 64 | Existing destination value, merged in the insert operation |
| amount_i | input | 6 | Rotate amount; only the low 5 bits are used |
| mb_i | input | 5 | Mask begin position, big-endian within the word |
| me_i | input | 5 | Mask end position, big-endian within the word |
| op_i | input | 1 | 0 = rotate AND mask, 1 = rotate and insert under mask |
| result_o | output | 64 | Merged result |

## Verification
The block holds no state, so a wrong mask combine or a wrong rotate stage shows at `result_o` in the same evaluation as the input change that exposes it. A swapped AND/OR choice fails at once on any contiguous field narrower than the word; the stated vector is one such case. It also fails on any wrapping field, where the wrong combine leaves only the two end fragments' overlap. The bench runs all 1024 begin/end pairs with random operands in both operations, so a fault in any rotate stage or any mask position reaches a port within one sweep.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

    typedef enum logic {
        RM_OP_AND    = 1'b0,
        RM_OP_INSERT = 1'b1
    } rm_op_e;

endpackage

// File: rtl/rm_rotator.sv
module rm_rotator #(
    parameter int WORD_W = 32,
    parameter int SH_W   = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [SH_W-1:0]   sh_i,
    output logic [WORD_W-1:0] word_o
);

    logic [SH_W:0][WORD_W-1:0] stage;

    assign stage[0] = word_i;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int STEP = 2 ** s;
        always_comb begin
            if (sh_i[s]) begin
                stage[s+1] = {stage[s][WORD_W-1-STEP:0], stage[s][WORD_W-1:WORD_W-STEP]};
            end else begin
                stage[s+1] = stage[s];
            end
        end
    end

    assign word_o = stage[SH_W];

endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = $clog2(WORD_W)
) (
    input  logic [IDX_W-1:0]  mb_i,
    input  logic [IDX_W-1:0]  me_i,
    output logic [WORD_W-1:0] begin_mask_o,
    output logic [WORD_W-1:0] end_mask_o,
    output logic [WORD_W-1:0] mask_o
);

    localparam logic [WORD_W-1:0] ALL_ONES = '1;
    localparam logic [IDX_W-1:0]  LAST_POS = IDX_W'(WORD_W - 1);

    logic [IDX_W-1:0] end_shift;
    logic             wraps;

    always_comb begin
        end_shift    = LAST_POS - me_i;
        begin_mask_o = ALL_ONES >> mb_i;
        end_mask_o   = ALL_ONES << end_shift;
        wraps        = (mb_i > me_i);
        if (wraps) begin
            mask_o = begin_mask_o | end_mask_o;
        end else begin
            mask_o = begin_mask_o & end_mask_o;
        end
    end

endmodule

// File: rtl/rm_merge.sv
module rm_merge
    import rotmask_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DATA_W = 64
) (
    input  logic [WORD_W-1:0] rot_i,
    input  logic [WORD_W-1:0] mask_i,
    input  logic [DATA_W-1:0] dest_i,
    input  rm_op_e            op_i,
    output logic [DATA_W-1:0] result_o
);

    localparam int COPIES = DATA_W / WORD_W;

    logic [DATA_W-1:0] rot_wide;
    logic [DATA_W-1:0] mask_wide;

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        assign rot_wide[c*WORD_W +: WORD_W] = rot_i;
    end

    assign mask_wide = {{(DATA_W-WORD_W){1'b0}}, mask_i};

    always_comb begin
        unique case (op_i)
            RM_OP_INSERT: result_o = (rot_wide & mask_wide) | (dest_i & ~mask_wide);
            default:      result_o = rot_wide & mask_wide;
        endcase
    end

endmodule

// File: rtl/rotmask_word_unit.sv
module rotmask_word_unit
    import rotmask_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DATA_W = 64,
    parameter int AMT_W  = 6,
    parameter int IDX_W  = $clog2(WORD_W)
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dest_i,
    input  logic [AMT_W-1:0]  amount_i,
    input  logic [IDX_W-1:0]  mb_i,
    input  logic [IDX_W-1:0]  me_i,
    input  logic              op_i,
    output logic [DATA_W-1:0] result_o
);

    logic [WORD_W-1:0] rot_word;
    logic [WORD_W-1:0] begin_mask;
    logic [WORD_W-1:0] end_mask;
    logic [WORD_W-1:0] word_mask;
    logic              unused_hi;

    assign unused_hi = ^{src_i[DATA_W-1:WORD_W], amount_i[AMT_W-1:IDX_W]};

    rm_rotator #(.WORD_W(WORD_W), .SH_W(IDX_W)) u_rot (
        .word_i (src_i[WORD_W-1:0]),
        .sh_i   (amount_i[IDX_W-1:0]),
        .word_o (rot_word)
    );

    rm_mask_gen #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_mask (
        .mb_i         (mb_i),
        .me_i         (me_i),
        .begin_mask_o (begin_mask),
        .end_mask_o   (end_mask),
        .mask_o       (word_mask)
    );

    rm_merge #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_merge (
        .rot_i    (rot_word),
        .mask_i   (word_mask),
        .dest_i   (dest_i),
        .op_i     (rm_op_e'(op_i)),
        .result_o (result_o)
    );

endmodule

// File: rtl/rotmask_word_unit_chk.sv
module rotmask_word_unit_chk #(
    parameter int WORD_W = 32,
    parameter int DATA_W = 64,
    parameter int IDX_W  = $clog2(WORD_W)
) (
    input logic [DATA_W-1:0] src_i,
    input logic [DATA_W-1:0] dest_i,
    input logic [IDX_W-1:0]  mb_i,
    input logic [IDX_W-1:0]  me_i,
    input logic              op_i,
    input logic [DATA_W-1:0] result_o,
    input logic [WORD_W-1:0] rot_word,
    input logic [WORD_W-1:0] word_mask
);

    logic [IDX_W-1:0] me_next;
    assign me_next = me_i + 1'b1;

    always_comb begin
        // R1
        rotate_ones_chk: assert ($countones(rot_word) == $countones(src_i[WORD_W-1:0]));
        // R2
        contig_width_chk: assert (mb_i > me_i ||
            $countones(word_mask) == int'(me_i) - int'(mb_i) + 1);
        // R3
        wrap_width_chk: assert (mb_i <= me_i ||
            $countones(word_mask) == WORD_W + 1 - int'(mb_i) + int'(me_i));
        // R4
        full_word_chk: assert (mb_i != me_next || word_mask == '1);
        // R5
        and_upper_zero_chk: assert (op_i || result_o[DATA_W-1:WORD_W] == '0);
        // R5
        and_outside_zero_chk: assert (op_i || (result_o[WORD_W-1:0] & ~word_mask) == '0);
        // R6
        insert_upper_chk: assert (!op_i || result_o[DATA_W-1:WORD_W] == dest_i[DATA_W-1:WORD_W]);
        // R6
        insert_outside_chk: assert (!op_i ||
            (result_o[WORD_W-1:0] & ~word_mask) == (dest_i[WORD_W-1:0] & ~word_mask));
    end

endmodule

bind rotmask_word_unit rotmask_word_unit_chk #(
    .WORD_W(WORD_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
    .src_i     (src_i),
    .dest_i    (dest_i),
    .mb_i      (mb_i),
    .me_i      (me_i),
    .op_i      (op_i),
    .result_o  (result_o),
    .rot_word  (rot_word),
    .word_mask (word_mask)
);

// File: tb/rotmask_word_unit_tb.sv
module rotmask_word_unit_tb;

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] dest;
        logic [5:0]  amt;
        logic [4:0]  mb;
        logic [4:0]  me;
        logic        op;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{64'h7ffdbffb91b906b9, 64'h0, 6'd31, 5'd16, 5'd20, 1'b0, 64'h0000000000008000, 8'd8},
        '{64'h7ffdbffb91b906b9, 64'hffffffffffffffff, 6'd31, 5'd16, 5'd20, 1'b1, 64'hffffffffffff87ff, 8'd6},
        '{64'h1, 64'h0, 6'd0, 5'd0, 5'd31, 1'b0, 64'h1, 8'd2},
        '{64'h1, 64'hffffffffffffffff, 6'd33, 5'd0, 5'd31, 1'b0, 64'h2, 8'd1},
        '{64'hffffffff00000000, 64'h0, 6'd0, 5'd0, 5'd31, 1'b0, 64'h0, 8'd7},
        '{64'hffffffff, 64'h0, 6'd0, 5'd31, 5'd0, 1'b0, 64'h80000001, 8'd3},
        '{64'h12345678, 64'h0, 6'd0, 5'd5, 5'd4, 1'b0, 64'h12345678, 8'd4},
        '{64'h0f0f0f0f, 64'haaaaaaaa55555555, 6'd0, 5'd5, 5'd4, 1'b1, 64'haaaaaaaa0f0f0f0f, 8'd4},
        '{64'hffffffff, 64'h0, 6'd0, 5'd0, 5'd0, 1'b0, 64'h80000000, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic [63:0] dest_i = '0;
    logic [5:0]  amount_i = '0;
    logic [4:0]  mb_i = '0;
    logic [4:0]  me_i = '0;
    logic        op_i = 1'b0;
    logic [63:0] result_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rotmask_word_unit u_dut (
        .src_i    (src_i),
        .dest_i   (dest_i),
        .amount_i (amount_i),
        .mb_i     (mb_i),
        .me_i     (me_i),
        .op_i     (op_i),
        .result_o (result_o)
    );

    function automatic logic [63:0] ref_model(input logic [63:0] s, input logic [63:0] d,
                                              input logic [5:0] a, input logic [4:0] b,
                                              input logic [4:0] e, input logic o);
        logic [31:0] rot;
        logic [31:0] m;
        logic [63:0] r;
        for (int i = 0; i < 32; i++) rot[i] = s[(i - int'(a[4:0]) + 32) % 32];
        for (int p = 0; p < 32; p++) begin
            if (b <= e) m[31-p] = (p >= int'(b)) && (p <= int'(e));
            else        m[31-p] = (p >= int'(b)) || (p <= int'(e));
        end
        r = {rot, rot} & {32'h0, m};
        if (o) r = r | (d & ~{32'h0, m});
        return r;
    endfunction

    task automatic apply(input logic [63:0] s, input logic [63:0] d, input logic [5:0] a,
                         input logic [4:0] b, input logic [4:0] e, input logic o,
                         input logic [63:0] exp, input string tag);
        @(negedge clk);
        src_i = s; dest_i = d; amount_i = a; mb_i = b; me_i = e; op_i = o;
        #5;
        checks++;
        if (result_o !== exp) begin
            fails++;
            $display("FAIL %s mb=%0d me=%0d op=%0b actual=%h expected=%h",
                     tag, b, e, o, result_o, exp);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-time state: all-zero inputs give a zero result (R5)
        apply(64'h0, 64'h0, 6'd0, 5'd0, 5'd0, 1'b0, 64'h0, "R5 idle");

        for (int k = 0; k < NVEC; k++) begin
            apply(VECS[k].src, VECS[k].dest, VECS[k].amt, VECS[k].mb, VECS[k].me,
                  VECS[k].op, VECS[k].exp, $sformatf("R%0d vec%0d", VECS[k].req, k));
        end

        // R8 stated vector again with unrelated destination: R5 dest ignored
        apply(64'h7ffdbffb91b906b9, 64'h123456789abcdef0, 6'd31, 5'd16, 5'd20, 1'b0,
              64'h8000, "R8 R5 dest ignored");
        // R7 upper source bits ignored under insert as well
        apply(64'hdeadbeef00000001, 64'h0, 6'd4, 5'd0, 5'd31, 1'b1, 64'h10, "R7 upper src");
        // R1 amount bit 5 has no effect
        apply(64'h80000000, 64'h0, 6'd33, 5'd0, 5'd31, 1'b0, 64'h1, "R1 amount msb");

        // Sweep all begin/end pairs: R2 R3 R4 R5 R6
        for (int b = 0; b < 32; b++) begin
            for (int e = 0; e < 32; e++) begin
                for (int o = 0; o < 2; o++) begin
                    logic [63:0] s;
                    logic [63:0] d;
                    logic [5:0]  a;
                    s = {$urandom, $urandom};
                    d = {$urandom, $urandom};
                    a = 6'($urandom);
                    apply(s, d, a, 5'(b), 5'(e), o[0],
                          ref_model(s, d, a, 5'(b), 5'(e), o[0]),
                          (b <= e) ? ((o == 0) ? "R2 R5 sweep" : "R2 R6 sweep")
                                   : ((o == 0) ? "R3 R5 sweep" : "R3 R6 sweep"));
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule